// File: doc/BRIEF.md
# Tick Range Extender

This block widens a free-running 32-bit system tick into a 56-bit tick. Only one 32-bit word of state is kept for this. The upper byte of that word remembers the tick's upper byte as of the last refresh. Its lower 24 bits count how many times the tick has wrapped.

A client pulses a query strobe. On that strobe the block compares the tick's current upper byte with the remembered one.

- **Bytes match:** the result is the 24-bit count placed above the 32-bit tick, and it comes back on the next cycle.
- **Bytes differ:** the word is refreshed first.
  - The remembered byte always takes the tick's present upper byte.
  - The count steps up by one only when the present byte is numerically below the remembered byte. That is the sign that the tick wrapped.
  - The block then evaluates again from the refreshed word and the tick value captured at the query. That result comes back one cycle later.

Wraps are never counted as they happen; they are inferred when a query arrives. For that reason, at least one query must reach the block in every full 32-bit wrap period of the tick. The block assumes that a single owner drives it.

Top module: `tick_range_extender`

## Requirements
- R1: Synchronous active-low reset. While `rst_n` is low at a clock edge:
  - `valid_o` goes low and `ext_tick_o` goes to zero.
  - The stored wrap count is cleared.
  - The remembered upper byte is loaded from `tick_i[31:24]`.
- R2: A result on `ext_tick_o` has the wrap count in bits 55:32 and the tick in bits 31:0. Whenever `valid_o` is high, bits 31:24 equal the remembered upper byte.
- R3: If `tick_i[31:24]` equals the remembered byte when a query is sampled:
  - `valid_o` is high in the following cycle.
  - The stored word does not change.
- R4: If the bytes differ and `tick_i[31:24]` is below the remembered byte, the wrap count increments by one.
- R5: If the bytes differ and `tick_i[31:24]` is above the remembered byte:
  - The wrap count is unchanged.
  - In every differing case, the remembered byte becomes `tick_i[31:24]`.
- R6: When an update is needed, `valid_o` stays low in the cycle after the query and rises in the cycle after that. The result is built from the refreshed word and the tick sampled with the query.
- R7: The wrap count wraps silently from all ones to zero.
- R8: A query presented in the cycle the block spends re-evaluating is ignored. The stored word is left untouched.
- R9: `valid_o` is a single-cycle pulse per query. `ext_tick_o` holds its last result until the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 32 | Free-running system tick |
| query_i | input | 1 | Request for an extended tick |
| ext_tick_o | output | 56 | Wrap count above the tick |
| valid_o | output | 1 | Result on `ext_tick_o` is new this cycle |

## Verification
Results are due at two latencies.

- **Matching upper byte:** the result is registered at the edge that samples the query. The bench drives on falling edges and checks at the falling edge that follows.
- **Update path:** the bench first confirms that `valid_o` is still low one falling edge after the query. It then checks the value one falling edge later.

After each result the bench confirms that `valid_o` has dropped. It also steers later queries so that an ignored query, or a silent count wrap, shows up as a wrong extended value. The count-wrap check runs on a second instance with a narrow count.

// File: rtl/tre_pkg.sv
// Shared types for the tick range extender.
package tre_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,   // waiting for a query
        ST_REEVAL = 1'b1    // word just refreshed, result pending
    } tre_state_e;
endpackage

// File: rtl/tre_compare.sv
// Compares the tick's upper byte against the remembered byte and forms
// the next extension word. Purely combinational; assumes the caller
// writes the word only when hit is low.
module tre_compare #(
    parameter int TICK_W  = 32,
    parameter int MATCH_W = 8,
    parameter int EXT_W   = 24
) (
    input  logic [TICK_W-1:0]  tick,
    input  logic [MATCH_W-1:0] match_q,
    input  logic [EXT_W-1:0]   count_q,
    output logic               hit,
    output logic               rollover,
    output logic [MATCH_W-1:0] nxt_match,
    output logic [EXT_W-1:0]   nxt_count
);
    localparam int TOP_LSB = TICK_W - MATCH_W;

    logic [MATCH_W-1:0] top;

    // Decide match / wrap and build the refreshed word.
    always_comb begin
        top       = tick[TICK_W-1:TOP_LSB];
        hit       = (top == match_q);
        rollover  = !hit && (top < match_q);
        nxt_match = top;
        nxt_count = count_q + EXT_W'(rollover);
    end
endmodule

// File: rtl/tre_word_reg.sv
// Holds the extension word: remembered upper byte and wrap count.
// Assumes init_match is the live tick's upper byte during reset.
module tre_word_reg #(
    parameter int MATCH_W = 8,
    parameter int EXT_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MATCH_W-1:0] init_match,
    input  logic               wr_en,
    input  logic [MATCH_W-1:0] nxt_match,
    input  logic [EXT_W-1:0]   nxt_count,
    output logic [MATCH_W-1:0] match_q,
    output logic [EXT_W-1:0]   count_q
);
    // Seed on reset, refresh on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= init_match;
            count_q <= '0;
        end else if (wr_en) begin
            match_q <= nxt_match;
            count_q <= nxt_count;
        end
    end
endmodule

// File: rtl/tick_range_extender.sv
// Extends a free-running tick with a lazily maintained wrap count.
// Assumes at least one query per full tick wrap period and a single owner.
module tick_range_extender #(
    parameter int TICK_W  = 32,
    parameter int MATCH_W = 8,
    parameter int EXT_W   = 24,
    localparam int OUT_W  = TICK_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] tick_i,
    input  logic              query_i,
    output logic [OUT_W-1:0]  ext_tick_o,
    output logic              valid_o
);
    import tre_pkg::*;

    localparam int TOP_LSB = TICK_W - MATCH_W;

    tre_state_e         state;
    logic [TICK_W-1:0]  snap_q;
    logic [OUT_W-1:0]   ext_q;
    logic               valid_q;
    logic [MATCH_W-1:0] match_q;
    logic [EXT_W-1:0]   count_q;
    logic               hit;
    logic               rollover;
    logic [MATCH_W-1:0] nxt_match;
    logic [EXT_W-1:0]   nxt_count;
    logic               wr_en;
    logic [TICK_W-1:0]  cmp_tick;
    logic [MATCH_W-1:0] tick_top;

    // Compare live tick when idle, captured tick when re-evaluating.
    always_comb begin
        cmp_tick = (state == ST_IDLE) ? tick_i : snap_q;
        tick_top = tick_i[TICK_W-1:TOP_LSB];
        wr_en    = (state == ST_IDLE) && query_i && !hit;
    end

    tre_compare #(.TICK_W(TICK_W), .MATCH_W(MATCH_W), .EXT_W(EXT_W)) u_cmp (
        .tick      (cmp_tick),
        .match_q   (match_q),
        .count_q   (count_q),
        .hit       (hit),
        .rollover  (rollover),
        .nxt_match (nxt_match),
        .nxt_count (nxt_count)
    );

    tre_word_reg #(.MATCH_W(MATCH_W), .EXT_W(EXT_W)) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_match (tick_top),
        .wr_en      (wr_en),
        .nxt_match  (nxt_match),
        .nxt_count  (nxt_count),
        .match_q    (match_q),
        .count_q    (count_q)
    );

    // Sequence queries and register results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            snap_q  <= '0;
            ext_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (query_i) begin
                        if (hit) begin
                            ext_q   <= {count_q, tick_i};
                            valid_q <= 1'b1;
                        end else begin
                            snap_q <= tick_i;
                            state  <= ST_REEVAL;
                        end
                    end
                end
                default: begin
                    ext_q   <= {count_q, snap_q};
                    valid_q <= 1'b1;
                    state   <= ST_IDLE;
                end
            endcase
        end
    end

    assign ext_tick_o = ext_q;
    assign valid_o    = valid_q;

    // R2: reported tick's upper byte agrees with the remembered byte
    assert_out_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (ext_tick_o[TICK_W-1:TOP_LSB] == match_q));

    // R3: a hit answers next cycle and leaves the word alone
    assert_hit_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && query_i && hit) |=>
        (valid_o && count_q == $past(count_q) && match_q == $past(match_q)));

    // R4: an inferred wrap bumps the count by one
    assert_rollover_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rollover) |=> (count_q == EXT_W'($past(count_q) + 1'b1)));

    // R5: any refresh takes the live upper byte
    assert_match_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (match_q == $past(tick_top)));

    // R6: update path answers one cycle later
    assert_update_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!valid_o && state == ST_REEVAL));
    assert_update_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REEVAL) |=> valid_o);

    // R8: a query during re-evaluation does not touch the word
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REEVAL && query_i) |=>
        (match_q == $past(match_q) && count_q == $past(count_q)));
endmodule

// File: tb/tb_tick_range_extender.sv
module tb_tick_range_extender;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tick_i = '0;
    logic        query_i = 1'b0;
    logic [55:0] ext_tick_o;
    logic        valid_o;

    logic [31:0] tick_s = '0;
    logic        query_s = 1'b0;
    logic [33:0] ext_s;
    logic        valid_s;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tick_range_extender dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .query_i(query_i),
        .ext_tick_o(ext_tick_o), .valid_o(valid_o));

    tick_range_extender #(.EXT_W(2)) dut_small (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_s), .query_i(query_s),
        .ext_tick_o(ext_s), .valid_o(valid_s));

    typedef struct packed {
        logic [31:0] tick;
        logic [55:0] ext;
        logic [1:0]  lat;
    } vec_t;

    // Reset tick is 0, so the remembered byte starts at 8'h00, count 0.
    localparam vec_t VECS [9] = '{
        '{32'h0000_0010, 56'h000000_00000010, 2'd1},
        '{32'h00FF_FFFF, 56'h000000_00FFFFFF, 2'd1},
        '{32'h3A00_0000, 56'h000000_3A000000, 2'd2},
        '{32'h3A12_3456, 56'h000000_3A123456, 2'd1},
        '{32'hFF00_0001, 56'h000000_FF000001, 2'd2},
        '{32'h0000_0005, 56'h000001_00000005, 2'd2},
        '{32'h0000_00AB, 56'h000001_000000AB, 2'd1},
        '{32'h8000_0000, 56'h000001_80000000, 2'd2},
        '{32'h7FFF_FFFF, 56'h000002_7FFFFFFF, 2'd2}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [31:0] t);
        @(negedge clk);
        rst_n = 1'b0; tick_i = t; tick_s = t; query_i = 1'b0; query_s = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One query on the main instance; checks latency, value and pulse end.
    task automatic query_main(input logic [31:0] t, input logic [55:0] exp,
                              input logic [1:0] lat, input string req);
        tick_i = t; query_i = 1'b1;
        @(negedge clk);
        query_i = 1'b0;
        if (lat == 2'd2) begin
            check("R6", 64'(valid_o), 64'd0);
            @(negedge clk);
        end
        check(lat == 2'd2 ? "R6" : "R3", 64'(valid_o), 64'd1);
        check(req, 64'(ext_tick_o), 64'(exp));
        @(negedge clk);
        check("R9", 64'(valid_o), 64'd0);
        check("R9", 64'(ext_tick_o), 64'(exp));
    endtask

    task automatic query_small(input logic [31:0] t);
        tick_s = t; query_s = 1'b1;
        @(negedge clk);
        query_s = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R1: reset state, byte seeded from live tick, count cleared
        do_reset(32'h5500_0000);
        check("R1", 64'(valid_o), 64'd0);
        check("R1", 64'(ext_tick_o), 64'd0);
        @(negedge clk);
        query_main(32'h5500_1234, 56'h000000_55001234, 2'd1, "R1");

        // Vector table walk: R2 layout, R3 hits, R4 wraps, R5 refreshes
        do_reset(32'h0000_0000);
        for (int i = 0; i < 9; i++) begin
            logic [23:0] prev_cnt;
            prev_cnt = (i == 0) ? 24'd0 : VECS[i-1].ext[55:32];
            query_main(VECS[i].tick, VECS[i].ext, VECS[i].lat,
                       (VECS[i].lat == 2'd1) ? "R2" :
                       (VECS[i].ext[55:32] != prev_cnt) ? "R4" : "R5");
        end

        // R8: query held into re-evaluation cycle is ignored
        do_reset(32'h0000_0000);
        tick_i = 32'h2000_0000; query_i = 1'b1;
        @(negedge clk);
        tick_i = 32'h1000_0000;
        check("R8", 64'(valid_o), 64'd0);
        @(negedge clk);
        query_i = 1'b0;
        check("R8", 64'(valid_o), 64'd1);
        check("R8", 64'(ext_tick_o), 64'h000000_20000000);
        @(negedge clk);
        query_main(32'h2000_0005, 56'h000000_20000005, 2'd1, "R8");

        // R7: two-bit count wraps to zero after four inferred wraps
        do_reset(32'h0000_0000);
        for (int k = 0; k < 3; k++) begin
            query_small(32'h8000_0000);
            query_small(32'h0000_0001);
        end
        check("R7", 64'(ext_s), 64'h3_0000_0001);
        query_small(32'h8000_0000);
        query_small(32'h0000_0001);
        check("R7", 64'(ext_s), 64'h0_0000_0001);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule